// File: doc/BRIEF.md
# Pseudo-Instruction Expander

This block sits in front of an instruction stream and turns one assembler convenience operation into the real 32-bit instruction words that carry it out. Each request arrives on a valid/ready handshake. A request holds an operation code, a destination register, a base or source register and a 32-bit value. The value is an immediate, an address or a memory offset, depending on the operation. After a request is taken, the block sends the expanded words out one per cycle on a second valid/ready stream. The final word of each sequence is marked with a flag.

Four operations are understood: register copy, load constant, load address and load word with a full 32-bit offset. A constant whose value is the sign extension of its low half needs only one word. Any other constant needs an upper-half load followed by a zero-extending OR of the lower half. An address always takes the two-word form. The far load builds the offset in scratch register 8, adds the base register to it, and then loads through it.

The request side is stalled from the moment a request is accepted until its last word has been taken downstream. An operation code the block does not understand is still accepted. It raises a one-cycle error pulse and produces no words.

The control is a three-state machine:
- `ST_IDLE`: ready for a request.
- `ST_EMIT`: presenting the word selected by a step counter.
- `ST_FAULT`: the error pulse.

Transitions:
- `ST_IDLE` to `ST_EMIT` on a known request.
- `ST_IDLE` to `ST_FAULT` on an unknown request.
- `ST_EMIT` back to `ST_IDLE` when the last word is accepted.
- `ST_FAULT` back to `ST_IDLE` after one cycle.

Top module: `psx_expander`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_err` is 0.
- R2: Operation code 0 (copy) produces one word: bits 31:26 = 8, bits 25:21 = `in_rs`, bits 20:16 = `in_rd`, bits 15:0 = 0.
- R3: Operation code 1 (constant), when `in_imm[31:16]` equals 16 copies of `in_imm[15]`, produces one word: bits 31:26 = 8, bits 25:21 = 0, bits 20:16 = `in_rd`, bits 15:0 = `in_imm[15:0]`.
- R4: Operation code 1 with any other value produces two words:
  - first: bits 31:26 = 15, bits 25:21 = 0, bits 20:16 = `in_rd`, bits 15:0 = `in_imm[31:16]`;
  - second: bits 31:26 = 13, bits 25:21 = `in_rd`, bits 20:16 = `in_rd`, bits 15:0 = `in_imm[15:0]`.
- R5: Operation code 2 (address) always produces the two-word pair of R4, even when the value is small.
- R6: Operation code 3 (far load) produces four words in this order:
  - {15, 0, 8, `in_imm[31:16]`};
  - {13, 8, 8, `in_imm[15:0]`};
  - an R-format word with opcode 0, bits 25:21 = `in_rs`, bits 20:16 = 8, bits 15:11 = 8, bits 10:6 = 0, bits 5:0 = 32;
  - {35, 8, `in_rd`, 0}.
- R7: The first word is valid in the cycle after the request is accepted. While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_last` hold their values.
- R8: `out_last` is 1 on the final word of a sequence and 0 on every earlier word. `out_valid` falls in the cycle after the final word is accepted.
- R9: `in_ready` is 0 from the cycle after a known request is accepted until the cycle after its final word is accepted.
- R10: Operation codes 4 to 7 are accepted. They give `out_err` = 1 for exactly the following cycle and produce no word. `in_ready` returns to 1 the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 3 | Operation code (0 copy, 1 constant, 2 address, 3 far load) |
| in_rd | input | 5 | Destination register number |
| in_rs | input | 5 | Source or base register number |
| in_imm | input | 32 | Immediate, address or offset |
| out_valid | output | 1 | Instruction word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Encoded instruction word |
| out_last | output | 1 | Final word of the sequence |
| out_err | output | 1 | One-cycle pulse for an unknown operation code |

## Verification
The assertions assume that the downstream side obeys the stream rules: once it sees a word, it only ever waits or accepts it. They also assume that `in_valid` is only sampled while `in_ready` is high, so requests sent during a sequence have no meaning. The stimulus raises `in_valid` only while the block is idle and drops it right after the accepting edge. `out_ready` is driven from the same negative-edge tasks, which insert wait cycles but never withdraw a word.

// File: rtl/psx_pkg.sv
package psx_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned OPC_W   = 3;
    localparam int unsigned STEP_W  = 2;
    localparam int unsigned HALF_W  = WORD_W / 2;

    localparam logic [OPC_W-1:0] OP_COPY    = 3'd0;
    localparam logic [OPC_W-1:0] OP_CONST   = 3'd1;
    localparam logic [OPC_W-1:0] OP_ADDR    = 3'd2;
    localparam logic [OPC_W-1:0] OP_FARLOAD = 3'd3;

    localparam logic [5:0] MOP_RTYPE = 6'd0;
    localparam logic [5:0] MOP_ADDI  = 6'd8;
    localparam logic [5:0] MOP_ORI   = 6'd13;
    localparam logic [5:0] MOP_LUI   = 6'd15;
    localparam logic [5:0] MOP_LW    = 6'd35;
    localparam logic [5:0] FN_ADD    = 6'd32;

    localparam logic [REG_W-1:0] REG_ZERO    = 5'd0;
    localparam logic [REG_W-1:0] REG_SCRATCH = 5'd8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_FAULT
    } state_e;

    function automatic logic [WORD_W-1:0] enc_i(
        input logic [5:0]        opc,
        input logic [REG_W-1:0]  rs,
        input logic [REG_W-1:0]  rt,
        input logic [HALF_W-1:0] imm
    );
        return {opc, rs, rt, imm};
    endfunction

    function automatic logic [WORD_W-1:0] enc_r(
        input logic [REG_W-1:0] rs,
        input logic [REG_W-1:0] rt,
        input logic [REG_W-1:0] rd,
        input logic [4:0]       sa,
        input logic [5:0]       fn
    );
        return {MOP_RTYPE, rs, rt, rd, sa, fn};
    endfunction
endpackage

// File: rtl/psx_sizer.sv
module psx_sizer
    import psx_pkg::*;
(
    input  logic [OPC_W-1:0]  op,
    input  logic [WORD_W-1:0] imm,
    output logic              known,
    output logic [STEP_W-1:0] last_idx
);
    logic fits_short;

    always_comb begin
        fits_short = (imm[WORD_W-1:HALF_W] == {HALF_W{imm[HALF_W-1]}});
        known      = 1'b1;
        last_idx   = '0;
        unique case (op)
            OP_COPY:    last_idx = 2'd0;
            OP_CONST:   last_idx = fits_short ? 2'd0 : 2'd1;
            OP_ADDR:    last_idx = 2'd1;
            OP_FARLOAD: last_idx = 2'd3;
            default: begin
                known    = 1'b0;
                last_idx = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/psx_encoder.sv
module psx_encoder
    import psx_pkg::*;
(
    input  logic [OPC_W-1:0]  op,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs,
    input  logic [WORD_W-1:0] imm,
    input  logic              short_form,
    input  logic [STEP_W-1:0] step,
    output logic [WORD_W-1:0] word
);
    logic [HALF_W-1:0] hi_half;
    logic [HALF_W-1:0] lo_half;

    always_comb begin
        hi_half = imm[WORD_W-1:HALF_W];
        lo_half = imm[HALF_W-1:0];
        word    = '0;
        unique case (op)
            OP_COPY: word = enc_i(MOP_ADDI, rs, rd, '0);
            OP_CONST, OP_ADDR: begin
                if (short_form && op == OP_CONST)
                    word = enc_i(MOP_ADDI, REG_ZERO, rd, lo_half);
                else if (step == 2'd0)
                    word = enc_i(MOP_LUI, REG_ZERO, rd, hi_half);
                else
                    word = enc_i(MOP_ORI, rd, rd, lo_half);
            end
            OP_FARLOAD: begin
                unique case (step)
                    2'd0: word = enc_i(MOP_LUI, REG_ZERO, REG_SCRATCH, hi_half);
                    2'd1: word = enc_i(MOP_ORI, REG_SCRATCH, REG_SCRATCH, lo_half);
                    2'd2: word = enc_r(rs, REG_SCRATCH, REG_SCRATCH, 5'd0, FN_ADD);
                    default: word = enc_i(MOP_LW, REG_SCRATCH, rd, '0);
                endcase
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/psx_fsm.sv
module psx_fsm
    import psx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              req_known,
    input  logic              out_ready,
    input  logic [STEP_W-1:0] last_idx,
    output logic              in_ready,
    output logic              out_valid,
    output logic              err,
    output logic              capture,
    output logic [STEP_W-1:0] step
);
    state_e state_q, state_d;
    logic [STEP_W-1:0] step_d;
    logic at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step    <= '0;
        end else begin
            state_q <= state_d;
            step    <= step_d;
        end
    end

    always_comb begin
        at_last = (step == last_idx);
        state_d = state_q;
        step_d  = step;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = req_known ? ST_EMIT : ST_FAULT;
                    step_d  = '0;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (at_last) state_d = ST_IDLE;
                    else         step_d  = step + 1'b1;
                end
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        err       = (state_q == ST_FAULT);
        capture   = (state_q == ST_IDLE) && in_valid && req_known;
    end

    // R9: the request side stays closed while a word is on offer
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10: the error pulse lasts one cycle and carries no word
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err && in_ready && !out_valid);

    // R8: the stream ends after the final word is taken
    p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && at_last |=> !out_valid && in_ready);
endmodule

// File: rtl/psx_expander.sv
module psx_expander
    import psx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [4:0]        in_rd,
    input  logic [4:0]        in_rs,
    input  logic [31:0]       in_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_word,
    output logic              out_last,
    output logic              out_err
);
    logic              req_known;
    logic [STEP_W-1:0] req_last;
    logic              capture;
    logic [STEP_W-1:0] step;

    logic [OPC_W-1:0]  op_q;
    logic [REG_W-1:0]  rd_q;
    logic [REG_W-1:0]  rs_q;
    logic [WORD_W-1:0] imm_q;
    logic [STEP_W-1:0] last_q;

    psx_sizer u_sizer (
        .op       (in_op),
        .imm      (in_imm),
        .known    (req_known),
        .last_idx (req_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            rd_q   <= '0;
            rs_q   <= '0;
            imm_q  <= '0;
            last_q <= '0;
        end else if (capture) begin
            op_q   <= in_op;
            rd_q   <= in_rd;
            rs_q   <= in_rs;
            imm_q  <= in_imm;
            last_q <= req_last;
        end
    end

    psx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .req_known (req_known),
        .out_ready (out_ready),
        .last_idx  (last_q),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .err       (out_err),
        .capture   (capture),
        .step      (step)
    );

    psx_encoder u_enc (
        .op         (op_q),
        .rd         (rd_q),
        .rs         (rs_q),
        .imm        (imm_q),
        .short_form (last_q == 2'd0),
        .step       (step),
        .word       (out_word)
    );

    assign out_last = out_valid && (step == last_q);

    // R7: a word waiting for the consumer does not change
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

    // R6: every far-load word except the last targets the scratch register
    p_scratch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op_q == OP_FARLOAD && !out_last |-> out_word[20:16] == REG_SCRATCH);
endmodule

// File: tb/test_psx_expander.sv
`timescale 1ns/1ps
module test_psx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_rd = '0;
    logic [4:0]  in_rs = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_last;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psx_expander i_psx_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_last(out_last), .out_err(out_err)
    );

    // {op, rd, rs, imm, expected word count}
    localparam logic [47:0] VEC [9] = '{
        {3'd0, 5'd9,  5'd19, 32'h0000_0000, 3'd1},  // R2 copy
        {3'd1, 5'd10, 5'd0,  32'h0000_0005, 3'd1},  // R3 small
        {3'd1, 5'd11, 5'd0,  32'hFFFF_FFFF, 3'd1},  // R3 minus one
        {3'd1, 5'd12, 5'd0,  32'hFFFF_8000, 3'd1},  // R3 lowest short
        {3'd1, 5'd13, 5'd0,  32'h0000_8000, 3'd2},  // R4 just too big
        {3'd1, 5'd14, 5'd0,  32'h1234_5678, 3'd2},  // R4
        {3'd2, 5'd15, 5'd0,  32'h0000_0010, 3'd2},  // R5 small address
        {3'd3, 5'd16, 5'd22, 32'h0001_2340, 3'd4},  // R6
        {3'd3, 5'd31, 5'd29, 32'hDEAD_BEEF, 3'd4}   // R6
    };

    function automatic logic [31:0] model(input logic [2:0] op, input logic [4:0] rd,
                                          input logic [4:0] rs, input logic [31:0] imm,
                                          input int k, input int n);
        case (op)
            3'd0: return {6'd8, rs, rd, 16'h0};
            3'd1, 3'd2: begin
                if (n == 1) return {6'd8, 5'd0, rd, imm[15:0]};
                if (k == 0) return {6'd15, 5'd0, rd, imm[31:16]};
                return {6'd13, rd, rd, imm[15:0]};
            end
            default: begin
                if (k == 0) return {6'd15, 5'd0, 5'd8, imm[31:16]};
                if (k == 1) return {6'd13, 5'd8, 5'd8, imm[15:0]};
                if (k == 2) return {6'd0, rs, 5'd8, 5'd8, 5'd0, 6'd32};
                return {6'd35, 5'd8, rd, 16'h0};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [4:0] rd, input logic [4:0] rs,
                          input logic [31:0] imm, input int n, input int stall, input string req);
        @(negedge clk);
        check("R9 idle before request", {31'd0, in_ready}, 32'd1);
        in_valid = 1'b1; in_op = op; in_rd = rd; in_rs = rs; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] w0;
            check({"R7 valid ", req}, {31'd0, out_valid}, 32'd1);
            check("R9 busy", {31'd0, in_ready}, 32'd0);
            w0 = out_word;
            if (stall > 0) begin
                out_ready = 1'b0;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check("R7 held valid", {31'd0, out_valid}, 32'd1);
                    check("R7 held word", out_word, w0);
                end
            end
            check(req, out_word, model(op, rd, rs, imm, k, n));
            check("R8 last flag", {31'd0, out_last}, (k == n - 1) ? 32'd1 : 32'd0);
            out_ready = 1'b1;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check("R8 stream ends", {31'd0, out_valid}, 32'd0);
        check("R9 ready again", {31'd0, in_ready}, 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 out_err", {31'd0, out_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {30'd0, in_ready, out_valid}, 32'd2);

        foreach (VEC[i]) begin
            string tag;
            case (VEC[i][47:45])
                3'd0: tag = "R2 copy";
                3'd1: tag = (VEC[i][2:0] == 3'd1) ? "R3 short const" : "R4 long const";
                3'd2: tag = "R5 address";
                default: tag = "R6 far load";
            endcase
            run_op(VEC[i][47:45], VEC[i][44:40], VEC[i][39:35], VEC[i][34:3],
                   int'(VEC[i][2:0]), 0, tag);
        end

        // R7 back-pressure on every word of a far load and a long constant
        run_op(3'd3, 5'd4, 5'd7, 32'h8000_0001, 4, 2, "R7 R6 stalled far load");
        run_op(3'd1, 5'd2, 5'd0, 32'h7FFF_FFFF, 2, 3, "R7 R4 stalled const");
        // R5 zero address still two words
        run_op(3'd2, 5'd3, 5'd0, 32'h0000_0000, 2, 1, "R5 zero address");

        // R10 unknown codes
        for (int c = 4; c < 8; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_op = 3'(c); in_rd = 5'd5; in_imm = 32'h1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R10 error pulse", {31'd0, out_err}, 32'd1);
            check("R10 no word", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
            check("R10 pulse ends", {31'd0, out_err}, 32'd0);
            check("R10 ready again", {30'd0, in_ready, out_valid}, 32'd2);
        end

        // R1 reset in the middle of a sequence
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd3; in_rd = 5'd1; in_rs = 5'd2; in_imm = 32'h0;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-sequence", {29'd0, in_ready, out_valid, out_err}, 32'd4);
        rst_n = 1'b1;
        run_op(3'd0, 5'd20, 5'd21, 32'h0, 1, 0, "R2 copy after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule